// File: doc/BRIEF.md
# Coherent Two-Byte Measurement Readback

This block stands between a bank of 16-bit measurement registers and a byte-wide register read port. Software fetches each measurement as two single-byte reads. A measurement engine can rewrite a live value between those two reads, so a plain readback could pair the upper half of one sample with the lower half of the next. This block prevents that.

When the upper byte of a measurement is read, the block copies that measurement's lower byte into a private holding register on the same clock edge. A later read of the lower-byte address returns the held copy and not the live value. The pair is therefore always taken from one sample, however long software waits between the two reads. Each measurement has its own holding copy. Reading the same upper byte again takes a new copy.

The measurement engine writes live values through one update strobe and one 16-bit data slice per measurement. Read data is registered and appears one cycle after the read strobe, together with a valid pulse.

Top module: `coherent_rb_latch`

## Requirements
- R1: A read of a measurement's upper-byte address returns bits 15:8 of that measurement's live value, as it was before the read's clock edge. The data appears on `rd_data` one cycle after `rd_en`, and `rd_valid` is high in that same cycle.
- R2: A read of measurement i's upper-byte address copies bits 7:0 of its live value into holding copy i on the same clock edge.
- R3: A read of measurement i's lower-byte address returns holding copy i. It does not return the live lower byte, even if the live value changed after the upper-byte read.
- R4: The held lower byte stays valid across any delay between the upper-byte read and the lower-byte read.
- R5: A repeated read of the same upper-byte address refreshes the holding copy, whether or not the lower byte was read in between.
- R6: Each measurement has its own holding copy. Reads of other measurements, and updates to them, leave it untouched.
- R7: An engine update in the same cycle as an upper-byte read of the same measurement does not split the pair. Both bytes come from the value before the update, and the next upper-byte read shows the new value.
- R8: After reset, every live value, every holding copy and `rd_data` are zero. A lower-byte read before any upper-byte read returns zero.
- R9: Measurement i has its upper byte at address 2i and its lower byte at address 2i+1. A read of any address at or above 2·N_MEAS returns zero with `rd_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_en | input | N_MEAS | Per-measurement strobe that writes a new live value |
| upd_data | input | N_MEAS*16 | New live values; measurement i uses bits 16i+15:16i |
| rd_en | input | 1 | Read strobe, one byte per cycle |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read strobe |

## Verification
The assertions assume that a read strobe and its address are stable across the clock edge that samples them. They also assume that `upd_data` carries a real value in every cycle where its strobe is high. They place no constraint on how updates and reads overlap, so same-cycle collisions fall inside what they check. The bench drives every input at the falling clock edge, so nothing changes near the sampling edge. It raises an update strobe only together with its data, and it deliberately lines up an update with an upper-byte read of the same measurement.

// File: rtl/rb_pkg.sv
// Package: shared widths for the coherent readback block.
// Assumes 16-bit measurements read as two bytes.
package rb_pkg;
    localparam int MEAS_W = 16;
    localparam int BYTE_W = MEAS_W / 2;
    typedef logic [BYTE_W-1:0] rb_byte_t;
endpackage

// File: rtl/rb_meas_store.sv
// Module: live measurement registers, written only by the measurement engine.
// Assumes upd_data is valid whenever the matching upd_en bit is high.
module rb_meas_store #(
    parameter int N_MEAS = 4,
    parameter int MEAS_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_MEAS-1:0]        upd_en,
    input  logic [N_MEAS*MEAS_W-1:0] upd_data,
    output logic [N_MEAS*MEAS_W-1:0] live
);
    for (genvar gi = 0; gi < N_MEAS; gi++) begin : g_meas
        // Hold each live value; load it on its own update strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                live[gi*MEAS_W +: MEAS_W] <= '0;
            else if (upd_en[gi])
                live[gi*MEAS_W +: MEAS_W] <= upd_data[gi*MEAS_W +: MEAS_W];
        end
    end
endmodule

// File: rtl/rb_hold_bank.sv
// Module: one holding copy of the lower byte per measurement.
// Assumes at most one cap_sel bit is high in any cycle.
module rb_hold_bank #(
    parameter int N_MEAS = 4,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [N_MEAS-1:0]        cap_sel,
    input  logic [N_MEAS*BYTE_W-1:0] live_lo,
    output logic [N_MEAS*BYTE_W-1:0] held
);
    for (genvar gi = 0; gi < N_MEAS; gi++) begin : g_hold
        // Copy the live lower byte when its upper byte is read.
        always_ff @(posedge clk) begin
            if (!rst_n)
                held[gi*BYTE_W +: BYTE_W] <= '0;
            else if (cap_sel[gi])
                held[gi*BYTE_W +: BYTE_W] <= live_lo[gi*BYTE_W +: BYTE_W];
        end

        // R2: capture takes the pre-edge live lower byte
        a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
            cap_sel[gi] |=> held[gi*BYTE_W +: BYTE_W] == $past(live_lo[gi*BYTE_W +: BYTE_W]));

        // R6: without its own capture the copy never moves
        a_r6_isolated: assert property (@(posedge clk) disable iff (!rst_n)
            !cap_sel[gi] |=> $stable(held[gi*BYTE_W +: BYTE_W]));
    end

    // R6: never more than one copy captured at once
    a_r6_one_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cap_sel));
endmodule

// File: rtl/rb_rd_path.sv
// Module: address decode, capture select and registered byte read mux.
// Assumes rd_addr is stable whenever rd_en is high.
module rb_rd_path #(
    parameter int N_MEAS = 4,
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_en,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [N_MEAS*2*BYTE_W-1:0] live,
    input  logic [N_MEAS*BYTE_W-1:0]   held,
    output logic [N_MEAS-1:0]          cap_sel,
    output logic [BYTE_W-1:0]          rd_data,
    output logic                       rd_valid
);
    localparam int MEAS_W = 2 * BYTE_W;
    localparam logic [ADDR_W-1:0] ADDR_END = ADDR_W'(2 * N_MEAS);

    logic              in_range;
    logic              is_lo;
    logic [BYTE_W-1:0] mux_byte;

    assign in_range = rd_addr < ADDR_END;
    assign is_lo    = rd_addr[0];

    // Select the addressed byte and flag the capture on upper-byte reads.
    always_comb begin
        mux_byte = '0;
        cap_sel  = '0;
        for (int i = 0; i < N_MEAS; i++) begin
            if (in_range && rd_addr[ADDR_W-1:1] == (ADDR_W-1)'(i)) begin
                if (is_lo) begin
                    mux_byte = held[i*BYTE_W +: BYTE_W];
                end else begin
                    mux_byte   = live[i*MEAS_W + BYTE_W +: BYTE_W];
                    cap_sel[i] = rd_en;
                end
            end
        end
    end

    // Register read data and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= mux_byte;
        end
    end

    for (genvar gi = 0; gi < N_MEAS; gi++) begin : g_chk
        // R1: upper-byte read returns the pre-edge live upper byte
        a_r1_hi_live: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == ADDR_W'(2*gi))
            |=> rd_data == $past(live[gi*MEAS_W + BYTE_W +: BYTE_W]));

        // R3: lower-byte read returns the holding copy
        a_r3_lo_held: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && rd_addr == ADDR_W'(2*gi + 1))
            |=> rd_data == $past(held[gi*BYTE_W +: BYTE_W]));
    end

    // R9: reads beyond the map return zero
    a_r9_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !in_range) |=> (rd_data == '0 && rd_valid));
endmodule

// File: rtl/coherent_rb_latch.sv
// Module: top of the coherent two-byte readback block.
// Assumes one byte read per cycle and an engine that drives full 16-bit values.
module coherent_rb_latch #(
    parameter int N_MEAS = 4,
    parameter int ADDR_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [N_MEAS-1:0]                  upd_en,
    input  logic [N_MEAS*rb_pkg::MEAS_W-1:0]   upd_data,
    input  logic                               rd_en,
    input  logic [ADDR_W-1:0]                  rd_addr,
    output logic [rb_pkg::BYTE_W-1:0]          rd_data,
    output logic                               rd_valid
);
    localparam int MW = rb_pkg::MEAS_W;
    localparam int BW = rb_pkg::BYTE_W;

    logic [N_MEAS*MW-1:0] live;
    logic [N_MEAS*BW-1:0] live_lo;
    logic [N_MEAS*BW-1:0] held;
    logic [N_MEAS-1:0]    cap_sel;

    for (genvar gi = 0; gi < N_MEAS; gi++) begin : g_lo
        assign live_lo[gi*BW +: BW] = live[gi*MW +: BW];
    end

    rb_meas_store #(.N_MEAS(N_MEAS), .MEAS_W(MW)) i_store (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_data(upd_data), .live(live)
    );

    rb_hold_bank #(.N_MEAS(N_MEAS), .BYTE_W(BW)) i_hold (
        .clk(clk), .rst_n(rst_n), .cap_sel(cap_sel), .live_lo(live_lo), .held(held)
    );

    rb_rd_path #(.N_MEAS(N_MEAS), .BYTE_W(BW), .ADDR_W(ADDR_W)) i_rd (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .live(live), .held(held), .cap_sel(cap_sel),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    // R1: valid follows every read strobe by one cycle
    a_r1_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);
endmodule

// File: tb/test_coherent_rb_latch.sv
module test_coherent_rb_latch;
    localparam int N = 4;
    localparam int AW = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    upd_en = '0;
    logic [N*16-1:0] upd_data = '0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   rd_addr = '0;
    logic [7:0]      rd_data;
    logic            rd_valid;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    coherent_rb_latch #(.N_MEAS(N), .ADDR_W(AW)) i_coherent_rb_latch (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_data(upd_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic upd(input int m, input logic [15:0] v);
        @(negedge clk);
        upd_en[m] = 1'b1;
        upd_data[m*16 +: 16] = v;
        @(negedge clk);
        upd_en = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check("R1 valid", {15'd0, rd_valid}, 16'd1);
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R8 rd_data", {8'd0, rd_data}, 16'd0);
        check("R8 rd_valid", {15'd0, rd_valid}, 16'd0);
        for (int m = 0; m < N; m++) begin
            rd(AW'(2*m+1), d);
            check("R8 lo before hi", {8'd0, d}, 16'd0);
        end
        rd(8'd0, d);
        check("R8 live zero", {8'd0, d}, 16'd0);
    endtask

    task automatic t_basic();
        logic [7:0] d;
        upd(0, 16'h1234);
        rd(8'd0, d); check("R1 hi", {8'd0, d}, 16'h12);
        rd(8'd1, d); check("R2 R3 lo", {8'd0, d}, 16'h34);
    endtask

    task automatic t_stale();
        logic [7:0] d;
        upd(1, 16'hABCD);
        rd(8'd2, d); check("R1 hi m1", {8'd0, d}, 16'hAB);
        upd(1, 16'h5678);
        rd(8'd3, d); check("R3 held not live", {8'd0, d}, 16'hCD);
        repeat (50) @(negedge clk);
        rd(8'd3, d); check("R4 after delay", {8'd0, d}, 16'hCD);
        rd(8'd2, d); check("R1 new hi", {8'd0, d}, 16'h56);
        rd(8'd3, d); check("R5 refreshed", {8'd0, d}, 16'h78);
    endtask

    task automatic t_refresh_no_lo();
        logic [7:0] d;
        upd(2, 16'h1111);
        rd(8'd4, d);
        upd(2, 16'h2222);
        rd(8'd4, d); check("R1 hi m2", {8'd0, d}, 16'h22);
        rd(8'd5, d); check("R5 refresh no lo", {8'd0, d}, 16'h22);
    endtask

    task automatic t_interleave();
        logic [7:0] d;
        upd(0, 16'h0A0B);
        upd(3, 16'h0C0D);
        rd(8'd0, d);
        rd(8'd6, d);
        upd(0, 16'hEEEE);
        upd(3, 16'hFFFF);
        rd(8'd1, d); check("R6 m0 copy", {8'd0, d}, 16'h0B);
        rd(8'd7, d); check("R6 m3 copy", {8'd0, d}, 16'h0D);
        rd(8'd5, d); check("R6 m2 untouched", {8'd0, d}, 16'h22);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        upd(0, 16'h1234);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'd0;
        upd_en[0] = 1'b1; upd_data[15:0] = 16'h9ABC;
        @(negedge clk);
        rd_en = 1'b0; upd_en = '0;
        check("R7 hi pre-update", {8'd0, rd_data}, 16'h12);
        rd(8'd1, d); check("R7 lo pre-update", {8'd0, d}, 16'h34);
        rd(8'd0, d); check("R7 next hi", {8'd0, d}, 16'h9A);
        rd(8'd1, d); check("R7 next lo", {8'd0, d}, 16'hBC);
    endtask

    task automatic t_range();
        logic [7:0] d;
        rd(8'd8, d); check("R9 addr 2N", {8'd0, d}, 16'h00);
        rd(8'hFF, d); check("R9 addr max", {8'd0, d}, 16'h00);
        rd(8'd6, d); check("R9 map m3 hi", {8'd0, d}, 16'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_stale();
        t_refresh_no_lo();
        t_interleave();
        t_collide();
        t_range();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule